// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block is a read-only bus target that makes an external serial flash look like a window of ordinary memory. A configuration port writes a switch register and one setup word per chip select. While the switch register's enable bit is set, the block owns the serial pins. Each bus read then becomes a complete flash read sequence: the block pulls one chip select low, sends an opcode and the address on a single line, clocks out the dummy bytes and collects 32 data bits on one, two or four lines. It returns the word with a one-cycle ready pulse.

The enable bit also appears on an output, so the surrounding logic can give the pins back to a command-driven engine when the bit is cleared. A read that finds the window disabled, or no valid chip select chosen, is answered at once with zero and does not touch the pins. The serial clock idles low. The block launches data on the falling edge and samples on the rising edge, and each half period lasts a parameterised number of system clocks.

Top module: `flash_map_reader`

## Requirements
- R1: The switch register sits at configuration offset 0x00. Its bit 0 enables the memory-mapped window. `mapMode` follows that bit, resets to 0, and drops to 0 when a 0 is written.
- R2: A bus read accepted while the window is off, or while the chip-select field is 0 or greater than NUM_CS, raises `busReady` in the following cycle with `busRdata` = 0. It asserts no chip select and produces no serial clock.
- R3: The setup word for chip select n is at configuration offset 0x10 + 4·n. It holds the opcode in bits 7:0, the address byte count minus one in bits 9:8, the dummy byte count in bits 11:10 and the line mode in bits 13:12. Line mode 0 is single, 1 is dual and 3 is quad. The value 2 behaves as single.
- R4: Switch register bits 10:8 select the chip select as (index + 1). For each bus read, exactly that `csN` bit goes low, once, and stays low for the whole sequence. No other `csN` bit goes low.
- R5: The opcode is sent first and then the low address bytes of `busAddr`, zero-extended to 32 bits. Both go out on `ioOut[0]` with `ioOe[0]` = 1, most significant bit first. Bits change after a falling edge of `sclk` and are stable at the rising edge.
- R6: Each dummy byte lasts 8 `sclk` cycles, and all `ioOe` bits are 0 during it. A dummy count of 0 leads straight from the address to the data.
- R7: Data is sampled on rising `sclk` edges, most significant bit first within each byte. Single mode takes 1 bit per edge from `ioIn[1]`. Dual mode takes 2 bits from `ioIn[1:0]`, with `ioIn[1]` as the higher bit. Quad mode takes 4 bits from `ioIn[3:0]`, with `ioIn[3]` as the highest bit.
- R8: The four data bytes come from ascending flash addresses. They are packed little-endian, so the byte at the bus address lands in `busRdata[7:0]`.
- R9: `busReady` is high for exactly one cycle per read, with all `csN` high. `busRdata` is 0 whenever `busReady` is low.
- R10: Whenever no chip select is asserted, `sclk` is 0 and `ioOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| busRead | input | 1 | Bus read request, one cycle |
| busAddr | input | BUS_AW | Byte address inside the flash window |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | One-cycle read completion |
| mapMode | output | 1 | Window enabled; the block owns the pins |
| sclk | output | 1 | Serial clock |
| csN | output | NUM_CS | Active-low chip selects |
| ioOut | output | 4 | Serial data out |
| ioOe | output | 4 | Serial data output enables |
| ioIn | input | 4 | Serial data in |

## Verification
The hardest part to reach from the ports is the data phase. It only forms correctly if the opcode, the address bytes and the dummy bytes all came out with the right count and order, and the flash side must drive data in step with the block's own clock. The bench contains a behavioural flash that decodes the address it actually received and serves bytes from a computed pattern. The returned word therefore checks the address path as well as the lane mapping. Directed reads cover every line mode, address widths of 1 to 4 bytes, dummy counts of 0 to 3, the reserved mode value, and invalid chip-select fields.

// File: rtl/fmr_pkg.sv
`timescale 1ns/1ps
package fmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_RESP
  } seqState_t;

  // Per-chip-select setup word; field order follows the register bit layout.
  typedef struct packed {
    logic [1:0] lineMode;
    logic [1:0] dummyBytes;
    logic [1:0] addrBytesM1;
    logic [7:0] opcode;
  } setupWord_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;      // capture opcode/address, clear receive register
    logic run;       // serial clock divider running
    logic txShift;   // advance the transmit register
    logic txDrive;   // drive data line 0
    logic rxSample;  // shift in one data chunk
    logic csOn;      // selected chip select asserted
    logic respond;   // present the read response
  } strobes_t;

  localparam logic [1:0] MODE_DUAL = 2'b01;
  localparam logic [1:0] MODE_QUAD = 2'b11;

  // Serial clock cycles needed for 32 data bits.
  function automatic logic [5:0] dataCycles(input logic [1:0] mode);
    case (mode)
      MODE_DUAL: dataCycles = 6'd16;
      MODE_QUAD: dataCycles = 6'd8;
      default:   dataCycles = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/fmr_ctrl.sv
`timescale 1ns/1ps
module fmr_ctrl
  import fmr_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CFG_AW = 5,
  parameter logic [CFG_AW-1:0] SWITCH_OFS = '0,
  parameter logic [CFG_AW-1:0] SETUP_BASE = CFG_AW'('h10),
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              busRead,
  input  logic              riseTick,
  input  logic              fallTick,
  output logic              mapMode,
  output strobes_t          strobes,
  output logic [7:0]        loadOpcode,
  output logic [1:0]        loadAddrM1,
  output logic [1:0]        lineMode,
  output logic [CS_W-1:0]   csIdx
);

  logic       swEnQ;
  logic [2:0] swCsQ;
  setupWord_t setupQ [NUM_CS];

  // Switch register: enable bit and chip-select field (index + 1).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEnQ <= 1'b0;
      swCsQ <= 3'd0;
    end else if (cfgWe && cfgAddr == SWITCH_OFS) begin
      swEnQ <= cfgWdata[0];
      swCsQ <= cfgWdata[10:8];
    end
  end

  // One setup word per chip select.
  for (genvar g = 0; g < NUM_CS; g++) begin : gSetup
    localparam logic [CFG_AW-1:0] OFS = SETUP_BASE + CFG_AW'(4 * g);
    always_ff @(posedge clk) begin
      if (!rstN) setupQ[g] <= '0;
      else if (cfgWe && cfgAddr == OFS) setupQ[g] <= setupWord_t'(cfgWdata[13:0]);
    end
  end

  logic unusedCfg;
  assign unusedCfg = ^{cfgWdata[31:14], cfgWdata[7:1]};

  // Chip-select selection.
  logic [2:0] csFieldM1;
  logic       selValid;
  setupWord_t selSetup;
  assign csFieldM1 = swCsQ - 3'd1;
  assign selValid  = swEnQ && (swCsQ != 3'd0) && (int'(swCsQ) <= NUM_CS);
  assign selSetup  = setupQ[csFieldM1[CS_W-1:0]];

  assign mapMode    = swEnQ;
  assign loadOpcode = selSetup.opcode;
  assign loadAddrM1 = selSetup.addrBytesM1;

  // Sequencer.
  seqState_t       stateQ, nextPhase;
  logic [5:0]      cntQ, phaseLen;
  logic [1:0]      actAddrM1Q, actDummyQ, actModeQ;
  logic [CS_W-1:0] csIdxQ;
  logic            lastCycle;

  always_comb begin
    case (stateQ)
      ST_CMD:   phaseLen = 6'd8;
      ST_ADDR:  phaseLen = {3'(actAddrM1Q) + 3'd1, 3'b000};
      ST_DUMMY: phaseLen = {1'b0, actDummyQ, 3'b000};
      ST_DATA:  phaseLen = dataCycles(actModeQ);
      default:  phaseLen = 6'd1;
    endcase
    case (stateQ)
      ST_CMD:   nextPhase = ST_ADDR;
      ST_ADDR:  nextPhase = (actDummyQ != 2'd0) ? ST_DUMMY : ST_DATA;
      ST_DUMMY: nextPhase = ST_DATA;
      ST_DATA:  nextPhase = ST_RESP;
      default:  nextPhase = ST_IDLE;
    endcase
  end
  assign lastCycle = (cntQ == phaseLen - 6'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cntQ       <= '0;
      actAddrM1Q <= '0;
      actDummyQ  <= '0;
      actModeQ   <= '0;
      csIdxQ     <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (busRead) begin
            cntQ <= '0;
            if (selValid) begin
              stateQ     <= ST_CMD;
              actAddrM1Q <= selSetup.addrBytesM1;
              actDummyQ  <= selSetup.dummyBytes;
              actModeQ   <= selSetup.lineMode;
              csIdxQ     <= csFieldM1[CS_W-1:0];
            end else begin
              stateQ <= ST_RESP;
            end
          end
        end
        ST_RESP: stateQ <= ST_IDLE;
        default: begin
          if (fallTick) begin
            if (lastCycle) begin
              cntQ   <= '0;
              stateQ <= nextPhase;
            end else begin
              cntQ <= cntQ + 6'd1;
            end
          end
        end
      endcase
    end
  end

  logic inFlash;
  assign inFlash = (stateQ == ST_CMD) || (stateQ == ST_ADDR) ||
                   (stateQ == ST_DUMMY) || (stateQ == ST_DATA);

  always_comb begin
    strobes          = '0;
    strobes.load     = (stateQ == ST_IDLE) && busRead;
    strobes.run      = inFlash;
    strobes.csOn     = inFlash;
    strobes.txDrive  = (stateQ == ST_CMD) || (stateQ == ST_ADDR);
    strobes.txShift  = strobes.txDrive && fallTick;
    strobes.rxSample = (stateQ == ST_DATA) && riseTick;
    strobes.respond  = (stateQ == ST_RESP);
  end

  assign lineMode = actModeQ;
  assign csIdx    = csIdxQ;

endmodule

// File: rtl/fmr_datapath.sv
`timescale 1ns/1ps
module fmr_datapath
  import fmr_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int BUS_AW   = 24,
  parameter int HALF_DIV = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [7:0]        loadOpcode,
  input  logic [1:0]        loadAddrM1,
  input  logic [1:0]        lineMode,
  input  logic [CS_W-1:0]   csIdx,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [3:0]        ioIn,
  output logic              riseTick,
  output logic              fallTick,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [31:0]       busRdata,
  output logic              busReady
);

  // Serial clock divider: each half period lasts HALF_DIV system clocks.
  logic [DIV_W-1:0] divQ;
  logic             sclkQ, halfEnd;
  assign halfEnd  = (divQ == DIV_W'(HALF_DIV - 1));
  assign riseTick = halfEnd && !sclkQ;
  assign fallTick = halfEnd && sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.run) begin
      divQ  <= '0;
      sclkQ <= 1'b0;
    end else if (halfEnd) begin
      divQ  <= '0;
      sclkQ <= ~sclkQ;
    end else begin
      divQ <= divQ + DIV_W'(1);
    end
  end
  assign sclk = sclkQ;

  // Transmit register: opcode then left-justified address, MSB first.
  logic [31:0] addrWide;
  logic [4:0]  addrShamt;
  logic [39:0] txQ;
  assign addrWide  = 32'(busAddr);
  assign addrShamt = {2'd3 - loadAddrM1, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN)               txQ <= '0;
    else if (strobes.load)   txQ <= {loadOpcode, addrWide << addrShamt};
    else if (strobes.txShift) txQ <= {txQ[38:0], 1'b0};
  end

  assign ioOut = {3'b000, strobes.txDrive & txQ[39]};
  assign ioOe  = {3'b000, strobes.txDrive};

  // Receive register: the first byte received ends up in the top byte.
  logic [31:0] rxQ;
  always_ff @(posedge clk) begin
    if (!rstN || strobes.load) begin
      rxQ <= '0;
    end else if (strobes.rxSample) begin
      case (lineMode)
        MODE_DUAL: rxQ <= {rxQ[29:0], ioIn[1:0]};
        MODE_QUAD: rxQ <= {rxQ[27:0], ioIn[3:0]};
        default:   rxQ <= {rxQ[30:0], ioIn[1]};
      endcase
    end
  end

  assign busReady = strobes.respond;
  assign busRdata = strobes.respond ? {rxQ[7:0], rxQ[15:8], rxQ[23:16], rxQ[31:24]} : 32'd0;

  for (genvar k = 0; k < NUM_CS; k++) begin : gCs
    assign csN[k] = !(strobes.csOn && csIdx == CS_W'(k));
  end

endmodule

// File: rtl/flash_map_reader.sv
`timescale 1ns/1ps
module flash_map_reader
  import fmr_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int BUS_AW   = 24,
  parameter int CFG_AW   = 5,
  parameter int HALF_DIV = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  logic              busRead,
  input  logic [BUS_AW-1:0] busAddr,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              mapMode,
  output logic              sclk,
  output logic [NUM_CS-1:0] csN,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn
);

  strobes_t        strobes;
  logic            riseTick, fallTick;
  logic [7:0]      loadOpcode;
  logic [1:0]      loadAddrM1, lineMode;
  logic [CS_W-1:0] csIdx;

  fmr_ctrl #(
    .NUM_CS(NUM_CS),
    .CFG_AW(CFG_AW)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .busRead   (busRead),
    .riseTick  (riseTick),
    .fallTick  (fallTick),
    .mapMode   (mapMode),
    .strobes   (strobes),
    .loadOpcode(loadOpcode),
    .loadAddrM1(loadAddrM1),
    .lineMode  (lineMode),
    .csIdx     (csIdx)
  );

  fmr_datapath #(
    .NUM_CS  (NUM_CS),
    .BUS_AW  (BUS_AW),
    .HALF_DIV(HALF_DIV)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadOpcode(loadOpcode),
    .loadAddrM1(loadAddrM1),
    .lineMode  (lineMode),
    .csIdx     (csIdx),
    .busAddr   (busAddr),
    .ioIn      (ioIn),
    .riseTick  (riseTick),
    .fallTick  (fallTick),
    .sclk      (sclk),
    .csN       (csN),
    .ioOut     (ioOut),
    .ioOe      (ioOe),
    .busRdata  (busRdata),
    .busReady  (busReady)
  );

endmodule

// File: rtl/fmr_checker.sv
`timescale 1ns/1ps
module fmr_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRead,
  input logic              busReady,
  input logic [31:0]       busRdata,
  input logic              mapMode,
  input logic              sclk,
  input logic [NUM_CS-1:0] csN,
  input logic [3:0]        ioOe
);

  logic csIdle;
  assign csIdle = &csN;

  p_single_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_cs_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    !csIdle |=> (csIdle || $stable(csN)));

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  p_ready_cs_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> csIdle);

  p_data_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busRdata == 32'd0));

  p_quiet_pins_r10: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |-> (!sclk && ioOe == 4'd0));

  p_disabled_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !mapMode && csIdle && !busReady) |=> (busReady && busRdata == 32'd0));

endmodule

bind flash_map_reader fmr_checker #(.NUM_CS(NUM_CS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busRead (busRead),
  .busReady(busReady),
  .busRdata(busRdata),
  .mapMode (mapMode),
  .sclk    (sclk),
  .csN     (csN),
  .ioOe    (ioOe)
);

// File: tb/tb_flash_map_reader.sv
`timescale 1ns/1ps
module tb_flash_map_reader;

  localparam int NUM_CS = 4;
  localparam int BUS_AW = 24;
  localparam int CFG_AW = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [CFG_AW-1:0] cfgAddr = '0;
  logic [31:0]       cfgWdata = '0;
  logic              busRead = 1'b0;
  logic [BUS_AW-1:0] busAddr = '0;
  logic [31:0]       busRdata;
  logic              busReady, mapMode, sclk;
  logic [NUM_CS-1:0] csN;
  logic [3:0]        ioOut, ioOe;
  logic [3:0]        ioIn = 4'd0;

  flash_map_reader #(.NUM_CS(NUM_CS), .BUS_AW(BUS_AW), .CFG_AW(CFG_AW)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busRead(busRead), .busAddr(busAddr), .busRdata(busRdata), .busReady(busReady),
    .mapMode(mapMode), .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Flash content pattern.
  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ 8'h5A ^ a[15:8];
  endfunction

  // ---------------- Behavioural flash ----------------
  int          mNb = 3, mDummy = 0, mW = 1;
  int          mRise = 0, mFall = 0;
  logic [39:0] mCap = '0;
  logic [31:0] mStream = '0;
  bit          mOeErr = 0;
  int          csEdges = 0;
  logic [NUM_CS-1:0] lastCsN = '1;
  logic        csActive;
  assign csActive = ~&csN;

  always @(posedge csActive) begin
    csEdges++;
    lastCsN = csN;
  end

  always @(posedge sclk) begin
    if (csActive) begin
      mRise++;
      if (mRise <= 8 + 8 * mNb) mCap = {mCap[38:0], ioOut[0]};
      else if (ioOe != 4'd0) mOeErr = 1;
    end
  end

  always @(negedge sclk) begin
    int pre;
    logic [63:0] mask;
    logic [31:0] a;
    if (csActive) begin
      mFall++;
      pre = 8 + 8 * mNb + 8 * mDummy;
      if (mFall == pre) begin
        mask = (64'd1 << (8 * mNb)) - 64'd1;
        a = mCap[31:0] & mask[31:0];
        mStream = {memByte(a), memByte(a + 1), memByte(a + 2), memByte(a + 3)};
      end else if (mFall > pre) begin
        mStream = mStream << mW;
      end
      if (mFall >= pre) begin
        if (mW == 1)      ioIn = {2'b00, mStream[31], 1'b0};
        else if (mW == 2) ioIn = {2'b00, mStream[31:30]};
        else              ioIn = mStream[31:28];
      end
    end
  end

  // ---------------- Helpers ----------------
  task automatic cfgWrite(input logic [CFG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [31:0] setupWord(input logic [7:0] op, input int nb, input int dm, input logic [1:0] mode);
    return {18'd0, mode, 2'(dm), 2'(nb - 1), op};
  endfunction

  function automatic logic [31:0] switchWord(input bit en, input logic [2:0] csField);
    return {21'd0, csField, 7'd0, en};
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] a);
    return {memByte(a + 3), memByte(a + 2), memByte(a + 1), memByte(a)};
  endfunction

  logic [31:0] rdData;
  int          rdLat;
  bit          rdAfter;
  int          rdEdges;

  task automatic doRead(input logic [BUS_AW-1:0] a);
    int e0;
    e0 = csEdges;
    mRise = 0; mFall = 0; mCap = '0; mOeErr = 0; ioIn = 4'd0;
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    @(negedge clk);
    busRead = 1'b0;
    rdLat = 0;
    while (!busReady && rdLat < 20000) begin
      @(negedge clk);
      rdLat++;
    end
    rdData = busRdata;
    @(negedge clk);
    rdAfter = busReady;
    rdEdges = csEdges - e0;
  endtask

  task automatic flashRead(input string tag, input int csI, input logic [7:0] op, input int nb,
                           input int dm, input logic [1:0] mode, input int w, input logic [BUS_AW-1:0] a);
    logic [63:0] mask;
    cfgWrite(CFG_AW'(16 + 4 * csI), setupWord(op, nb, dm, mode));
    cfgWrite('0, switchWord(1'b1, 3'(csI + 1)));
    mNb = nb; mDummy = dm; mW = w;
    doRead(a);
    mask = (64'd1 << (8 * nb)) - 64'd1;
    check(rdLat < 20000, {tag, " R9 response"}, 64'(rdLat), 0);
    check(8'(mCap >> (8 * nb)) == op, {tag, " R5 opcode"}, 64'(8'(mCap >> (8 * nb))), 64'(op));
    check((mCap[31:0] & mask[31:0]) == (32'(a) & mask[31:0]), {tag, " R5 address"},
          64'(mCap[31:0] & mask[31:0]), 64'(32'(a) & mask[31:0]));
    check(mRise == 8 + 8 * nb + 8 * dm + 32 / w, {tag, " R6 sclk cycle count"},
          64'(mRise), 64'(8 + 8 * nb + 8 * dm + 32 / w));
    check(!mOeErr, {tag, " R6 lines released"}, 64'(mOeErr), 0);
    check(rdData == expWord(32'(a)), {tag, " R7 R8 data"}, 64'(rdData), 64'(expWord(32'(a))));
    check(rdEdges == 1 && lastCsN == ~(NUM_CS'(1) << csI), {tag, " R4 chip select"},
          64'({rdEdges[7:0], 4'(lastCsN)}), 64'({8'd1, 4'(~(NUM_CS'(1) << csI))}));
    check(!rdAfter, {tag, " R9 ready single cycle"}, 64'(rdAfter), 0);
    check(&csN && !sclk && ioOe == 4'd0, {tag, " R10 pins idle"}, 64'({csN, sclk, ioOe}), 64'({4'hF, 1'b0, 4'h0}));
  endtask

  task automatic zeroRead(input string tag, input logic [BUS_AW-1:0] a);
    doRead(a);
    check(rdLat == 0, {tag, " R2 immediate ready"}, 64'(rdLat), 0);
    check(rdData == 32'd0, {tag, " R2 zero data"}, 64'(rdData), 0);
    check(rdEdges == 0, {tag, " R2 no chip select"}, 64'(rdEdges), 0);
    check(!rdAfter, {tag, " R9 ready single cycle"}, 64'(rdAfter), 0);
  endtask

  // ---------------- Scenarios ----------------
  task automatic testReset();
    check(mapMode == 1'b0, "R1 reset mapMode", 64'(mapMode), 0);
    check(&csN && !sclk && ioOe == 4'd0, "R10 reset pins", 64'({csN, sclk, ioOe}), 64'({4'hF, 1'b0, 4'h0}));
    check(!busReady && busRdata == 32'd0, "R9 reset response", 64'({busReady, busRdata}), 0);
  endtask

  task automatic testDisabled();
    cfgWrite(CFG_AW'(16), setupWord(8'h03, 3, 0, 2'b00));
    zeroRead("disabled", 24'h000100);
  endtask

  task automatic testSingle();
    flashRead("single", 0, 8'h03, 3, 1, 2'b00, 1, 24'h0A5C10);
    check(mapMode == 1'b1, "R1 mapMode set", 64'(mapMode), 1);
  endtask

  task automatic testDual();
    flashRead("dual", 1, 8'h3B, 4, 0, 2'b01, 2, 24'hC3_7F24);
  endtask

  task automatic testQuad();
    flashRead("quad", 2, 8'h6B, 2, 3, 2'b11, 4, 24'h01_B3E8);
  endtask

  task automatic testReservedMode();
    flashRead("mode2 R3", 3, 8'hA7, 1, 2, 2'b10, 1, 24'h00_0044);
  endtask

  task automatic testBadCs();
    cfgWrite('0, switchWord(1'b1, 3'd0));
    zeroRead("csfield0", 24'h000200);
    cfgWrite('0, switchWord(1'b1, 3'd5));
    zeroRead("csfield5", 24'h000204);
  endtask

  task automatic testSwitchOff();
    cfgWrite('0, switchWord(1'b0, 3'd1));
    @(negedge clk);
    check(mapMode == 1'b0, "R1 mapMode cleared", 64'(mapMode), 0);
    zeroRead("switched off", 24'h0A5C10);
  endtask

  // ---------------- Main ----------------
  bit done = 0;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testSingle();
    testDual();
    testQuad();
    testReservedMode();
    testBadCs();
    testSwitchOff();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule